// File: doc/BRIEF.md
# Suspend Modulation Duty Controller

This block slows a processor by toggling a suspend request between an active phase and an idle phase. Two programmable counts set how long each phase lasts, measured in ticks of a fixed-period strobe. The pair of phases repeats for as long as modulation is allowed. The ratio of the two counts therefore sets the effective speed of the processor.

Activity on interrupts, video or system-management events can pause the modulation so that the processor runs at full speed. Two speedup timers handle the timed pauses. A system-management event follows one of two policies. It can start a timed pause, or it can hold full speed until software reads a release register.

Software programs the block through a small register port. Writes land on the clock edge. Reads return data combinationally from the address.

Top module: `susp_mod_top`

## Requirements
- R1: With an active count A and an idle count B, suspReq, sampled in each cycle where tick is high, shows A ones followed by B zeros, and the pair repeats. The active count is at address 0 and the idle count at address 1.
- R2: The config register is at address 2. Modulation runs only when both bit 0 (modulation on) and bit 2 (power management on) are set. Otherwise suspReq stays low.
- R3: The IRQ speedup count is at address 3. An irqEvt pulse holds suspReq low for that many ticks. Modulation then restarts with a full active phase. A new pulse during the pause reloads the full count.
- R4: The video speedup count is at address 4. A videoEvt pulse holds suspReq low for that many ticks, and modulation then restarts with a full active phase.
- R5: With config bit 1 clear, an smiEvt pulse loads the IRQ speedup timer and pauses modulation for the IRQ speedup count.
- R6: With config bit 1 set, an smiEvt pulse holds suspReq low until the release register at address 5 is read. That read returns zero.
- R7: A read of the release register while modulation is not enabled leaves a pending hold in place.
- R8: suspAck does not change phase timing. Its value is returned in bit 7 of a config register read.
- R9: An active count of zero keeps suspReq low. An idle count of zero with a nonzero active count keeps suspReq high.
- R10: A new phase count written during a phase takes effect only when that phase is next entered.
- R11: After reset, every register reads as zero and suspReq is low.
- R12: When an smiEvt pulse (config bit 1 set) and a release read fall in the same cycle, the hold is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (used by the release register) |
| regAddr | input | 3 | Register address |
| regWrData | input | CNT_W | Write data |
| regRdData | output | CNT_W | Read data, combinational from regAddr |
| tick | input | 1 | Single-cycle time-base strobe |
| irqEvt | input | 1 | Interrupt activity pulse |
| videoEvt | input | 1 | Video activity pulse |
| smiEvt | input | 1 | System-management event pulse |
| suspAck | input | 1 | Suspend acknowledge from the processor |
| suspReq | output | 1 | Suspend request to the processor |

## Verification
The collision that matters is a system-management event and a software release read in the same clock cycle. The first sets the hold and the second clears it. The bench raises smiEvt and a read of address 5 on the same edge, then checks that suspReq stays low across several ticks. A second release read on its own must then bring the active phase back. A speedup event that lands while its timer is still running is the other overlap. The bench judges it by counting the paused ticks after a reload.

// File: rtl/susp_mod_pkg.sv
package susp_mod_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_ON  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_OFF = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CFG = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_IRQ = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_VID = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_REL = 3'd5;

  localparam int CFG_MOD = 0;
  localparam int CFG_SMI = 1;
  localparam int CFG_GLB = 2;
  localparam int CFG_W   = 3;

  localparam int TMR_N   = 2;
  localparam int TMR_IRQ = 0;
  localparam int TMR_VID = 1;

  typedef struct packed {
    logic loadOn;
    logic loadOff;
    logic decRem;
  } phase_strb_t;

  typedef struct packed {
    logic running;
    logic remZero;
    logic remOne;
    logic onZero;
    logic offZero;
  } phase_stat_t;

endpackage

// File: rtl/susp_speedup_tmr.sv
module susp_speedup_tmr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [CNT_W-1:0] loadVal,
  input  logic             tick,
  output logic             busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      cnt <= '0;
    else if (load)                  cnt <= loadVal;
    else if (tick && cnt != '0)     cnt <= cnt - CNT_W'(1);
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/susp_mod_dp.sv
module susp_mod_dp
  import susp_mod_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  regRdData,
  input  logic              tick,
  input  logic              irqEvt,
  input  logic              videoEvt,
  input  logic              smiEvt,
  input  logic              suspAck,
  input  phase_strb_t       strb,
  output phase_stat_t       stat,
  output logic              modActive,
  output logic              smiHold,
  output logic              smiModeHold,
  output logic [CNT_W-1:0]  irqSpdCnt
);
  logic [CNT_W-1:0] onCnt, offCnt, vidSpdCnt, rem;
  logic [CFG_W-1:0] cfg;
  logic             relRd;
  logic [TMR_N-1:0] tmrLoad, tmrBusy;
  logic [CNT_W-1:0] tmrVal [TMR_N];

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onCnt     <= '0;
      offCnt    <= '0;
      cfg       <= '0;
      irqSpdCnt <= '0;
      vidSpdCnt <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_ON:  onCnt     <= regWrData;
        ADDR_OFF: offCnt    <= regWrData;
        ADDR_CFG: cfg       <= regWrData[CFG_W-1:0];
        ADDR_IRQ: irqSpdCnt <= regWrData;
        ADDR_VID: vidSpdCnt <= regWrData;
        default:  ;
      endcase
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_ON:  regRdData = onCnt;
      ADDR_OFF: regRdData = offCnt;
      ADDR_CFG: regRdData = {suspAck, {(CNT_W-CFG_W-1){1'b0}}, cfg};
      ADDR_IRQ: regRdData = irqSpdCnt;
      ADDR_VID: regRdData = vidSpdCnt;
      default:  regRdData = '0;
    endcase
  end

  assign modActive   = cfg[CFG_GLB] & cfg[CFG_MOD];
  assign smiModeHold = cfg[CFG_SMI];
  assign relRd       = regRdEn && (regAddr == ADDR_REL);

  // SMI hold: a new event wins over a same-cycle release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        smiHold <= 1'b0;
    else if (smiEvt && smiModeHold)   smiHold <= 1'b1;
    else if (relRd && modActive)      smiHold <= 1'b0;
  end

  // speedup timers
  assign tmrLoad[TMR_IRQ] = irqEvt | (smiEvt & ~smiModeHold);
  assign tmrVal[TMR_IRQ]  = irqSpdCnt;
  assign tmrLoad[TMR_VID] = videoEvt;
  assign tmrVal[TMR_VID]  = vidSpdCnt;

  for (genvar g = 0; g < TMR_N; g++) begin : g_tmr
    susp_speedup_tmr #(.CNT_W(CNT_W)) tmr_i (
      .clk    (clk),
      .rstN   (rstN),
      .load   (tmrLoad[g]),
      .loadVal(tmrVal[g]),
      .tick   (tick),
      .busy   (tmrBusy[g])
    );
  end

  // phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rem <= '0;
    else if (strb.loadOn)  rem <= onCnt;
    else if (strb.loadOff) rem <= offCnt;
    else if (strb.decRem)  rem <= rem - CNT_W'(1);
  end

  assign stat.running = modActive & ~(|tmrBusy) & ~smiHold;
  assign stat.remZero = (rem == '0);
  assign stat.remOne  = (rem == CNT_W'(1));
  assign stat.onZero  = (onCnt == '0);
  assign stat.offZero = (offCnt == '0);
endmodule

// File: rtl/susp_mod_ctl.sv
module susp_mod_ctl
  import susp_mod_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  phase_stat_t stat,
  output phase_strb_t strb,
  output logic        suspReq
);
  logic idleQ, idleNxt, inOnQ, inOnNxt, phaseEnd;

  assign phaseEnd = stat.remZero | (tick & stat.remOne);

  always_comb begin
    strb    = '0;
    idleNxt = idleQ;
    inOnNxt = inOnQ;
    if (!stat.running) begin
      idleNxt = 1'b1;
    end else if (idleQ) begin
      strb.loadOn = 1'b1;
      idleNxt     = 1'b0;
      inOnNxt     = 1'b1;
    end else if (phaseEnd) begin
      if (inOnQ) begin
        if (stat.offZero) strb.loadOn = 1'b1;
        else begin
          strb.loadOff = 1'b1;
          inOnNxt      = 1'b0;
        end
      end else begin
        if (stat.onZero) strb.loadOff = 1'b1;
        else begin
          strb.loadOn = 1'b1;
          inOnNxt     = 1'b1;
        end
      end
    end else if (tick) begin
      strb.decRem = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleQ <= 1'b1;
      inOnQ <= 1'b0;
    end else begin
      idleQ <= idleNxt;
      inOnQ <= inOnNxt;
    end
  end

  assign suspReq = stat.running & ~idleQ & inOnQ & ~stat.remZero;
endmodule

// File: rtl/susp_mod_top.sv
module susp_mod_top
  import susp_mod_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  regRdData,
  input  logic              tick,
  input  logic              irqEvt,
  input  logic              videoEvt,
  input  logic              smiEvt,
  input  logic              suspAck,
  output logic              suspReq
);
  phase_strb_t      strb;
  phase_stat_t      stat;
  logic             modActive, smiHold, smiModeHold;
  logic [CNT_W-1:0] irqSpdCnt;

  susp_mod_dp #(.CNT_W(CNT_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .tick       (tick),
    .irqEvt     (irqEvt),
    .videoEvt   (videoEvt),
    .smiEvt     (smiEvt),
    .suspAck    (suspAck),
    .strb       (strb),
    .stat       (stat),
    .modActive  (modActive),
    .smiHold    (smiHold),
    .smiModeHold(smiModeHold),
    .irqSpdCnt  (irqSpdCnt)
  );

  susp_mod_ctl ctl_i (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .stat   (stat),
    .strb   (strb),
    .suspReq(suspReq)
  );
endmodule

// File: rtl/susp_mod_chk.sv
module susp_mod_chk
  import susp_mod_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              suspReq,
  input logic              modActive,
  input logic              smiHold,
  input logic              smiModeHold,
  input logic              irqEvt,
  input logic              smiEvt,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [CNT_W-1:0]  irqSpdCnt
);
  // R2: no request without both enables
  a_r2_off_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !modActive |-> !suspReq);

  // R3: an IRQ pulse with a nonzero count pauses the request next cycle
  a_r3_irq_pause: assert property (@(posedge clk) disable iff (!rstN)
    (irqEvt && irqSpdCnt != '0) |=> !suspReq);

  // R6: pending SMI hold blocks the request
  a_r6_hold_blocks: assert property (@(posedge clk) disable iff (!rstN)
    smiHold |-> !suspReq);

  // R7: release read while disabled keeps the hold
  a_r7_release_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_REL && !modActive && smiHold) |=> smiHold);

  // R12: SMI and release in the same cycle leaves the hold set
  a_r12_smi_wins: assert property (@(posedge clk) disable iff (!rstN)
    (smiEvt && smiModeHold && regRdEn && regAddr == ADDR_REL) |=> smiHold);
endmodule

bind susp_mod_top susp_mod_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .suspReq    (suspReq),
  .modActive  (modActive),
  .smiHold    (smiHold),
  .smiModeHold(smiModeHold),
  .irqEvt     (irqEvt),
  .smiEvt     (smiEvt),
  .regRdEn    (regRdEn),
  .regAddr    (regAddr),
  .irqSpdCnt  (irqSpdCnt)
);

// File: tb/susp_mod_top_tb_top.sv
module susp_mod_top_tb_top;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]       regAddr = '0;
  logic [CNT_W-1:0] regWrData = '0;
  logic [CNT_W-1:0] regRdData;
  logic             tick = 1'b0, irqEvt = 1'b0, videoEvt = 1'b0, smiEvt = 1'b0;
  logic             suspAck = 1'b0;
  logic             suspReq;
  logic             wiggleAck = 1'b0;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  susp_mod_top #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .tick(tick), .irqEvt(irqEvt), .videoEvt(videoEvt), .smiEvt(smiEvt),
    .suspAck(suspAck), .suspReq(suspReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [CNT_W-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [CNT_W-1:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: irqEvt = 1'b1;
      1: videoEvt = 1'b1;
      default: smiEvt = 1'b1;
    endcase
    @(negedge clk);
    irqEvt = 1'b0; videoEvt = 1'b0; smiEvt = 1'b0;
  endtask

  task automatic doTick(output logic r);
    repeat (3) begin
      @(negedge clk);
      if (wiggleAck) suspAck = ~suspAck;
    end
    tick = 1'b1;
    r = suspReq;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // samples n ticks; bit i of pat is the expected request at tick i
  task automatic expectTicks(input string req, input int n, input logic [31:0] pat);
    logic [31:0] got = '0;
    for (int i = 0; i < n; i++) begin
      logic r;
      doTick(r);
      got[i] = r;
    end
    check(req, got, pat & ((32'd1 << n) - 32'd1));
  endtask

  task automatic restart(input logic [CNT_W-1:0] cfgVal);
    writeReg(3'd2, 8'h00);
    writeReg(3'd2, cfgVal);
  endtask

  task automatic setCounts(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
    writeReg(3'd0, a);
    writeReg(3'd1, b);
  endtask

  task automatic tReset();
    logic [CNT_W-1:0] d;
    check("R11 req", {31'd0, suspReq}, 32'd0);
    for (int a = 0; a < 6; a++) begin
      readReg(3'(a), d);
      check("R11 reg", {24'd0, d}, 32'd0);
    end
  endtask

  task automatic tPattern();
    setCounts(8'd2, 8'd3);
    restart(8'h05);
    expectTicks("R1 pattern 2/3", 10, 32'h063);
  endtask

  task automatic tAck();
    logic [CNT_W-1:0] d;
    restart(8'h05);
    wiggleAck = 1'b1;
    expectTicks("R8 ack ignored", 10, 32'h063);
    wiggleAck = 1'b0;
    suspAck = 1'b1;
    readReg(3'd2, d);
    check("R8 ack readback", {24'd0, d}, 32'h85);
    suspAck = 1'b0;
  endtask

  task automatic tEnables();
    setCounts(8'd2, 8'd2);
    restart(8'h01);
    expectTicks("R2 global off", 4, 32'h0);
    restart(8'h04);
    expectTicks("R2 mod off", 4, 32'h0);
    restart(8'h05);
    expectTicks("R2 both on", 1, 32'h1);
  endtask

  task automatic tZero();
    setCounts(8'd0, 8'd3);
    restart(8'h05);
    expectTicks("R9 active zero", 8, 32'h00);
    setCounts(8'd3, 8'd0);
    restart(8'h05);
    expectTicks("R9 idle zero", 8, 32'hFF);
  endtask

  task automatic tLateWrite();
    setCounts(8'd2, 8'd2);
    restart(8'h05);
    expectTicks("R10 first", 1, 32'h1);
    writeReg(3'd0, 8'd4);
    expectTicks("R10 deferred", 9, 32'h079);
  endtask

  task automatic tIrq();
    setCounts(8'd2, 8'd2);
    writeReg(3'd3, 8'd3);
    restart(8'h05);
    expectTicks("R3 before", 2, 32'h3);
    pulse(0);
    expectTicks("R3 pause", 2, 32'h0);
    pulse(0);
    expectTicks("R3 reload", 7, 32'h18);
  endtask

  task automatic tVideo();
    setCounts(8'd2, 8'd2);
    writeReg(3'd4, 8'd2);
    restart(8'h05);
    expectTicks("R4 before", 1, 32'h1);
    pulse(1);
    expectTicks("R4 pause", 6, 32'h0C);
  endtask

  task automatic tSmiTimed();
    writeReg(3'd3, 8'd3);
    restart(8'h05);
    pulse(2);
    expectTicks("R5 timed", 4, 32'h8);
  endtask

  task automatic tSmiHold();
    logic [CNT_W-1:0] d;
    restart(8'h07);
    pulse(2);
    expectTicks("R6 held", 6, 32'h0);
    readReg(3'd5, d);
    check("R6 release data", {24'd0, d}, 32'd0);
    expectTicks("R6 resumed", 4, 32'h3);
  endtask

  task automatic tReleaseDisabled();
    logic [CNT_W-1:0] d;
    restart(8'h07);
    pulse(2);
    writeReg(3'd2, 8'h06);
    readReg(3'd5, d);
    writeReg(3'd2, 8'h07);
    expectTicks("R7 hold kept", 4, 32'h0);
    readReg(3'd5, d);
    expectTicks("R7 then release", 1, 32'h1);
  endtask

  task automatic tCollision();
    logic [CNT_W-1:0] d;
    restart(8'h07);
    @(negedge clk);
    smiEvt = 1'b1; regRdEn = 1'b1; regAddr = 3'd5;
    @(negedge clk);
    smiEvt = 1'b0; regRdEn = 1'b0;
    expectTicks("R12 smi wins", 4, 32'h0);
    readReg(3'd5, d);
    expectTicks("R12 release", 1, 32'h1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tPattern();
    tAck();
    tEnables();
    tZero();
    tLateWrite();
    tIrq();
    tVideo();
    tSmiTimed();
    tSmiHold();
    tReleaseDisabled();
    tCollision();
    summary();
  end
endmodule